// File: doc/BRIEF.md
# ADC Sweep Conversion Sequencer

This block controls a multi-channel analog-to-digital converter. Each start event runs one sweep. A sweep covers the first 2, 4, 6 or 8 channels in ascending order. The first thing a sweep does is capture channels 0 and 1 together, on two hold circuits, in the same clock cycle. The channels are then converted one at a time through a request/done handshake with an abstract converter. Each result lands in that channel's own result register. A single-cycle interrupt marks the end of the sweep.

Software starts a sweep in one of two ways. In software mode, writing the start bit to 1 launches the sweep at once, and the bit clears itself when the sweep ends. In hardware mode, the start bit only arms the block. The sweep then waits for one of four selected events: a falling edge on the external trigger pin, or an underflow pulse from one of three timer sources. The start bit stays set afterwards, so the block re-arms for the next event. Writing the start bit to 0 halts the block at any time.

Top module: `adc_sweep_seq`

## Requirements
- R1: After reset, every request line and the interrupt are low, the start bit reads 0, and all eight result registers read 0.
- R2: In software mode (`hw_mode`=0), writing 1 to the start bit at a clock edge drives the hold strobe two cycles after that write cycle.
- R3: Every sweep asserts both bits of `sh_strobe` in one single cycle, exactly once. The next cycle carries the convert request for channel 0.
- R4: Convert requests carry channels 0 up to 2*`sweep_sel`+1 in ascending order. Only one is outstanding at a time, and no further request follows the last channel.
- R5: On `conv_done`, `conv_data` is stored in the result register of the channel being converted. It can be read through `rd_ch`/`rd_data`, and the other registers keep their values.
- R6: One cycle after the final `conv_done`, `irq` pulses for exactly one cycle. In software mode the start bit reads 0 from then on.
- R7: In hardware mode, writing the start bit only arms the block. The hold strobe comes one cycle after the selected event. `trig_src` encodes the event: 0 = falling edge of `ext_trig_n`, 1 = `tmr0_uf`, 2 = `tmr2_uf`, 3 = `tmr2f_uf`.
- R8: With source 0, only a high-to-low change of `ext_trig_n` seen while armed starts a sweep. A pin that is already low at arming, or a rising edge, starts nothing.
- R9: In hardware mode the start bit stays 1 after a sweep, and the next event starts another sweep. Events during a running sweep are ignored.
- R10: Writing 0 to the start bit halts a running sweep. No further request and no interrupt follow, and a late `conv_done` leaves the result registers unchanged.
- R11: Pulses on event inputs that `trig_src` does not select start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_we | input | 1 | Write strobe for the start bit |
| start_wd | input | 1 | Value written to the start bit |
| start_o | output | 1 | Current start bit |
| hw_mode | input | 1 | 0 = software start, 1 = hardware event start |
| trig_src | input | 2 | Hardware event select |
| sweep_sel | input | 2 | Sweep length: 2*(value+1) channels |
| ext_trig_n | input | 1 | External trigger pin, active on a falling edge |
| tmr0_uf | input | 1 | Timer 0 underflow pulse |
| tmr2_uf | input | 1 | Timer 2 underflow pulse |
| tmr2f_uf | input | 1 | Timer 2 interrupt-frequency counter underflow pulse |
| sh_strobe | output | 2 | Hold strobes for channels 0 and 1 |
| conv_req | output | 1 | One-cycle convert request |
| conv_ch | output | 3 | Channel of the current conversion |
| conv_done | input | 1 | Conversion finished pulse |
| conv_data | input | 10 | Conversion result |
| rd_ch | input | 3 | Result register select |
| rd_data | output | 10 | Selected result register |
| irq | output | 1 | Sweep-complete interrupt pulse |

## Verification
The bench targets these corner cases:

- **Hold strobe.** It must be a single joint strobe on both bits. A design that strobed the two hold circuits in different cycles would be reported.
- **Sweep end.** Requests must stop exactly at the last selected channel. A design with an off-by-one end would issue one request too many or too few.
- **Trigger pin at arming.** The external pin is held low while arming. A level-sensitive or unarmed edge detector would start a sweep that must not happen.
- **Events during a sweep.** Events are injected while a sweep runs. A design that did not ignore them would run a second sweep.
- **Halt before done.** A halt is written before a pending done arrives. A design that kept writing results after the halt would corrupt a stored value.
- **Start bit at sweep end.** A design that cleared the start bit in hardware mode would never run the next triggered sweep.

// File: rtl/adc_sweep_pkg.sv
package adc_sweep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_CONV = 2'd2,
        ST_WAIT = 2'd3
    } sweep_st_e;

    typedef enum logic [1:0] {
        SRC_PIN   = 2'd0,
        SRC_TMR0  = 2'd1,
        SRC_TMR2  = 2'd2,
        SRC_TMR2F = 2'd3
    } trig_src_e;

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_sweep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic [1:0] src,
    input  logic       pin_n,
    input  logic       tmr0_uf,
    input  logic       tmr2_uf,
    input  logic       tmr2f_uf,
    output logic       fire
);

    typedef struct packed {
        logic pin;
    } trig_t;

    trig_t q, d;
    logic  pin_fall;

    always_comb begin
        d     = q;
        d.pin = pin_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{pin: 1'b1};
        else        q <= d;
    end

    assign pin_fall = q.pin && !pin_n;

    always_comb begin
        fire = 1'b0;
        if (armed) begin
            case (trig_src_e'(src))
                SRC_PIN:   fire = pin_fall;
                SRC_TMR0:  fire = tmr0_uf;
                SRC_TMR2:  fire = tmr2_uf;
                SRC_TMR2F: fire = tmr2f_uf;
                default:   fire = 1'b0;
            endcase
        end
    end

    // R11: an event only counts while armed
    a_r11_fire_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> armed);

endmodule

// File: rtl/adc_sweep_fsm.sv
module adc_sweep_fsm
    import adc_sweep_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SEL_W  = 2,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_we,
    input  logic             start_wd,
    input  logic             hw_mode,
    input  logic [SEL_W-1:0] sweep_sel,
    input  logic             fire,
    input  logic             conv_done,
    output logic             armed,
    output logic             start_o,
    output logic [1:0]       sh_strobe,
    output logic             conv_req,
    output logic [CH_W-1:0]  conv_ch,
    output logic             wr_en,
    output logic [CH_W-1:0]  wr_ch,
    output logic             irq
);

    typedef struct packed {
        sweep_st_e       st;
        logic            start;
        logic [CH_W-1:0] ch;
        logic [CH_W-1:0] last;
        logic            irq;
    } fsm_t;

    fsm_t q, d;
    logic go;

    assign go = q.start && (hw_mode ? fire : 1'b1);

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        wr_en = 1'b0;
        if (start_we) d.start = start_wd;
        case (q.st)
            ST_IDLE: begin
                if (go) begin
                    d.st   = ST_HOLD;
                    d.ch   = '0;
                    d.last = CH_W'({sweep_sel, 1'b1});
                end
            end
            ST_HOLD: d.st = ST_CONV;
            ST_CONV: d.st = ST_WAIT;
            ST_WAIT: begin
                if (conv_done) begin
                    wr_en = 1'b1;
                    if (q.ch == q.last) begin
                        d.st  = ST_IDLE;
                        d.irq = 1'b1;
                        if (!hw_mode) d.start = 1'b0;
                    end else begin
                        d.ch = q.ch + 1'b1;
                        d.st = ST_CONV;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (q.st != ST_IDLE && !q.start) begin
            d.st  = ST_IDLE;
            d.irq = 1'b0;
            wr_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, start: 1'b0, ch: '0, last: '0, irq: 1'b0};
        else        q <= d;
    end

    assign armed     = (q.st == ST_IDLE) && q.start && hw_mode;
    assign start_o   = q.start;
    assign sh_strobe = {2{q.st == ST_HOLD}};
    assign conv_req  = (q.st == ST_CONV);
    assign conv_ch   = q.ch;
    assign wr_ch     = q.ch;
    assign irq       = q.irq;

    // R3: joint hold is followed by the channel 0 request
    a_r3_hold_then_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        sh_strobe[0] |=> (conv_req && conv_ch == '0));
    // R4: never two requests back to back
    a_r4_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);
    // R4: requested channel within the selected sweep
    a_r4_ch_bound: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (conv_ch <= q.last));
    // R6: interrupt is a single-cycle pulse
    a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R10: a cleared start bit ends any running sweep
    a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && !q.start) |=> (q.st == ST_IDLE && !irq));
    // R7: in hardware mode an idle block waits for an event
    a_r7_hw_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && hw_mode && !fire) |=> (q.st == ST_IDLE));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_data
);

    typedef logic [RES_W-1:0] word_t;

    word_t mem_q [NUM_CH];
    word_t mem_d [NUM_CH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_ch] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_ch];

    // R5: a write lands in the addressed register
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_ch)] == $past(wr_data)));

endmodule

// File: rtl/adc_sweep_seq.sv
module adc_sweep_seq #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10,
    parameter int SEL_W  = 2,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_we,
    input  logic             start_wd,
    output logic             start_o,
    input  logic             hw_mode,
    input  logic [1:0]       trig_src,
    input  logic [SEL_W-1:0] sweep_sel,
    input  logic             ext_trig_n,
    input  logic             tmr0_uf,
    input  logic             tmr2_uf,
    input  logic             tmr2f_uf,
    output logic [1:0]       sh_strobe,
    output logic             conv_req,
    output logic [CH_W-1:0]  conv_ch,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_data,
    output logic             irq
);

    logic            armed;
    logic            fire;
    logic            wr_en;
    logic [CH_W-1:0] wr_ch;

    adc_trig_sel u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .src      (trig_src),
        .pin_n    (ext_trig_n),
        .tmr0_uf  (tmr0_uf),
        .tmr2_uf  (tmr2_uf),
        .tmr2f_uf (tmr2f_uf),
        .fire     (fire)
    );

    adc_sweep_fsm #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_we  (start_we),
        .start_wd  (start_wd),
        .hw_mode   (hw_mode),
        .sweep_sel (sweep_sel),
        .fire      (fire),
        .conv_done (conv_done),
        .armed     (armed),
        .start_o   (start_o),
        .sh_strobe (sh_strobe),
        .conv_req  (conv_req),
        .conv_ch   (conv_ch),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .irq       (irq)
    );

    adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_data (conv_data),
        .rd_ch   (rd_ch),
        .rd_data (rd_data)
    );

    // R3: both hold circuits are strobed together
    a_r3_joint_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_strobe != 2'b00) |-> (sh_strobe == 2'b11));
    // R6: interrupt follows a conversion done
    a_r6_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(conv_done));

endmodule

// File: tb/tb_adc_sweep_seq.sv
module tb_adc_sweep_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_we = 1'b0, start_wd = 1'b0, start_o;
    logic       hw_mode = 1'b0;
    logic [1:0] trig_src = 2'd0, sweep_sel = 2'd0;
    logic       ext_trig_n = 1'b1, tmr0_uf = 1'b0, tmr2_uf = 1'b0, tmr2f_uf = 1'b0;
    logic [1:0] sh_strobe;
    logic       conv_req;
    logic [2:0] conv_ch;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic [2:0] rd_ch = '0;
    logic [9:0] rd_data;
    logic       irq;

    adc_sweep_seq dut (.*);

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    int cyc = 0;
    int irq_cnt = 0, sh_cnt = 0, req_cnt = 0, sh_cyc = 0, wr_cyc = 0;
    int exp_q[$];
    int exp_res[8];
    int tag = 0;
    int resp_dly = 0;
    bit write_ok = 1'b1;
    bit pend = 1'b0;
    int pend_ch = 0, pend_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor and converter model: pops expected channels, answers with done
    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (rst_n) begin
            if (pend) begin
                if (pend_cnt == 0) begin
                    automatic logic [9:0] v = 10'((tag * 37 + pend_ch * 53 + 5) & 10'h3ff);
                    conv_done <= 1'b1;
                    conv_data <= v;
                    if (write_ok) exp_res[pend_ch] = int'(v);
                    pend = 1'b0;
                end else begin
                    pend_cnt--;
                end
            end
            if (sh_strobe != 2'b00) begin
                sh_cnt++;
                sh_cyc = cyc;
                chk(sh_strobe == 2'b11, "R3 joint hold", int'(sh_strobe), 3);
            end
            if (irq) irq_cnt++;
            if (conv_req) begin
                req_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected request", int'(conv_ch), -1);
                end else begin
                    automatic int e = exp_q.pop_front();
                    chk(int'(conv_ch) == e, "R4 channel order", int'(conv_ch), e);
                end
                pend     = 1'b1;
                pend_ch  = int'(conv_ch);
                pend_cnt = resp_dly;
            end
        end
    end

    task automatic wr_start(input bit v);
        @(negedge clk);
        start_we = 1'b1;
        start_wd = v;
        wr_cyc   = cyc;
        @(negedge clk);
        start_we = 1'b0;
    endtask

    task automatic push_sweep(input int sel);
        tag++;
        for (int c = 0; c < 2 * (sel + 1); c++) exp_q.push_back(c);
    endtask

    task automatic wait_irq(input int target);
        int t = 0;
        while (irq_cnt < target && t < 1000) begin
            @(posedge clk);
            t++;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_src(input int k);
        @(negedge clk);
        wr_cyc = cyc;
        case (k)
            1: tmr0_uf = 1'b1;
            2: tmr2_uf = 1'b1;
            default: tmr2f_uf = 1'b1;
        endcase
        @(negedge clk);
        tmr0_uf = 1'b0; tmr2_uf = 1'b0; tmr2f_uf = 1'b0;
    endtask

    task automatic read_all(input string req);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            rd_ch = 3'(c);
            #1;
            chk(int'(rd_data) == exp_res[c], req, int'(rd_data), exp_res[c]);
        end
    endtask

    task automatic sw_sweep(input int sel);
        int i0 = irq_cnt, s0 = sh_cnt;
        hw_mode = 1'b0;
        sweep_sel = 2'(sel);
        push_sweep(sel);
        wr_start(1'b1);
        wait_irq(i0 + 1);
        idle(10);
        chk(sh_cyc - wr_cyc == 2, "R2 start latency", sh_cyc - wr_cyc, 2);
        chk(sh_cnt == s0 + 1, "R3 one hold per sweep", sh_cnt - s0, 1);
        chk(exp_q.size() == 0, "R4 all channels requested", exp_q.size(), 0);
        chk(irq_cnt == i0 + 1, "R6 one interrupt", irq_cnt - i0, 1);
        chk(start_o == 1'b0, "R6 start self-clears", int'(start_o), 0);
        read_all("R5 result readback");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++) exp_res[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq == 1'b0, "R1 irq low", int'(irq), 0);
        chk(start_o == 1'b0, "R1 start low", int'(start_o), 0);
        chk(conv_req == 1'b0, "R1 no request", int'(conv_req), 0);
        chk(sh_strobe == 2'b00, "R1 no hold", int'(sh_strobe), 0);
        read_all("R1 results zero");

        // Software sweeps of every length
        for (int s = 0; s < 4; s++) sw_sweep(s);
        sw_sweep(1);

        // Hardware mode, timer 0 source
        begin
            int i0, s0, r0;
            hw_mode = 1'b1; trig_src = 2'd1; sweep_sel = 2'd1;
            s0 = sh_cnt; r0 = req_cnt;
            wr_start(1'b1);
            idle(8);
            chk(sh_cnt == s0 && req_cnt == r0, "R7 arm only", sh_cnt - s0, 0);
            pulse_src(2);
            pulse_src(3);
            idle(8);
            chk(sh_cnt == s0, "R11 unselected source ignored", sh_cnt - s0, 0);
            i0 = irq_cnt;
            push_sweep(1);
            pulse_src(1);
            wait_irq(i0 + 1);
            idle(5);
            chk(sh_cyc - wr_cyc == 1, "R7 event latency", sh_cyc - wr_cyc, 1);
            chk(irq_cnt == i0 + 1, "R7 sweep completes", irq_cnt - i0, 1);
            chk(start_o == 1'b1, "R9 start stays set", int'(start_o), 1);
            read_all("R5 hardware readback");
        end

        // Events during a sweep are ignored; re-arm works
        begin
            int i0, s0, r0;
            trig_src = 2'd2; sweep_sel = 2'd3;
            i0 = irq_cnt; s0 = sh_cnt;
            push_sweep(3);
            pulse_src(2);
            r0 = req_cnt;
            while (req_cnt == r0) @(posedge clk);
            pulse_src(2);
            pulse_src(2);
            wait_irq(i0 + 1);
            idle(20);
            chk(sh_cnt == s0 + 1, "R9 mid-sweep event ignored", sh_cnt - s0, 1);
            chk(irq_cnt == i0 + 1, "R9 single interrupt", irq_cnt - i0, 1);
            sweep_sel = 2'd0;
            push_sweep(0);
            pulse_src(2);
            wait_irq(i0 + 2);
            idle(5);
            chk(irq_cnt == i0 + 2, "R9 re-armed sweep", irq_cnt - i0, 2);
            trig_src = 2'd3;
            push_sweep(0);
            pulse_src(3);
            wait_irq(i0 + 3);
            idle(5);
            chk(irq_cnt == i0 + 3, "R7 counter source", irq_cnt - i0, 3);
            read_all("R5 after re-arm");
        end

        // External pin source
        begin
            int i0, s0;
            wr_start(1'b0);
            trig_src = 2'd0; sweep_sel = 2'd2;
            @(negedge clk);
            ext_trig_n = 1'b0;
            idle(3);
            s0 = sh_cnt; i0 = irq_cnt;
            wr_start(1'b1);
            idle(10);
            chk(sh_cnt == s0, "R8 low pin at arm ignored", sh_cnt - s0, 0);
            ext_trig_n = 1'b1;
            idle(5);
            chk(sh_cnt == s0, "R8 rising edge ignored", sh_cnt - s0, 0);
            push_sweep(2);
            wr_cyc = cyc;
            ext_trig_n = 1'b0;
            wait_irq(i0 + 1);
            idle(5);
            chk(sh_cyc - wr_cyc == 1, "R8 falling edge starts", sh_cyc - wr_cyc, 1);
            chk(irq_cnt == i0 + 1, "R8 sweep completes", irq_cnt - i0, 1);
            ext_trig_n = 1'b1;
            wr_start(1'b0);
            idle(3);
        end

        // Halt before a pending done
        begin
            int i0, r0;
            hw_mode = 1'b0; sweep_sel = 2'd3;
            resp_dly = 5; write_ok = 1'b0;
            tag++;
            exp_q.push_back(0);
            i0 = irq_cnt; r0 = req_cnt;
            wr_start(1'b1);
            while (req_cnt == r0) @(posedge clk);
            wr_start(1'b0);
            idle(30);
            chk(req_cnt == r0 + 1, "R10 no request after halt", req_cnt - r0, 1);
            chk(irq_cnt == i0, "R10 no interrupt after halt", irq_cnt - i0, 0);
            chk(start_o == 1'b0, "R10 start reads 0", int'(start_o), 0);
            read_all("R10 results untouched");
            resp_dly = 0; write_ok = 1'b1;
        end

        sw_sweep(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule